// File: doc/BRIEF.md
# SIMD Scalar Integer Three-Operand Unit

This block takes one 32-bit instruction word from the scalar "three registers of the same width" SIMD group and either executes it on 64-bit operands or reports why it cannot. It slices the word into a destination index, two source indices, a 5-bit opcode, a 2-bit size field and an unsigned-variant bit. It then sorts the word into one of three classes: executable, recognised but not implemented here, or unallocated. For an executable word it reads both sources from a 32-entry register file, computes the result and writes it back to the destination, all in the cycle the word is accepted.

The executable set is wrapping add and subtract, plus five compares: signed and unsigned greater-than, signed and unsigned greater-or-equal, equality, and bit-test. A compare writes a full-width mask, either all ones or all zeros. Saturating arithmetic, shifts, doubling multiplies and floating-point words are never executed. They only raise the "unsupported" or "unallocated" flag.

A fill port writes a register directly, so that operands can be set up before execution. Every accepted word gives exactly one `done` pulse on the next cycle. The two class flags and the write-back report travel with that pulse.

Top module: `simd_scalar3_unit`

## Requirements
- R1: Fields are taken from fixed bit positions of `in_word`: destination index [4:0], first source [9:5], opcode [15:11], second source [20:16], size [23:22], unsigned bit U at bit 29. The first source is operand A, the second is operand B, and the result goes to the destination register.
- R2: Opcode 0x10 with size 3 writes A+B when U=0 and A−B when U=1, both wrapping modulo 2^64.
- R3: Opcode 0x06 with size 3 tests A>B, signed when U=0 and unsigned when U=1.
- R4: Opcode 0x07 with size 3 tests A>=B, signed when U=0 and unsigned when U=1.
- R5: Opcode 0x11 with size 3 tests A==B when U=1, and tests (A AND B)!=0 when U=0.
- R6: A compare writes 0xFFFF_FFFF_FFFF_FFFF when its test holds and 0 when it does not.
- R7: Opcodes 0x06, 0x07, 0x10 and 0x11 with a size other than 3 raise `flag_unalloc` and write no register.
- R8: Opcodes 0x01, 0x05, 0x08, 0x09, 0x0A and 0x0B raise `flag_unsupp`. Opcode 0x16 raises `flag_unsupp` when size is 1 or 2, and `flag_unalloc` otherwise.
- R9: For opcode ≥ 0x18, the 7-bit code {U, size[1], opcode} selects the flag. Codes 0x1B, 0x1C, 0x1F, 0x3F, 0x5C, 0x5D, 0x7A, 0x7C and 0x7D raise `flag_unsupp`. All other codes raise `flag_unalloc`.
- R10: Every opcode below 0x18 that R2–R8 do not name raises `flag_unalloc`. A flagged word never writes a register, and at most one flag is high at a time.
- R11: A word sampled with `in_valid` high at a rising edge produces `done`=1 for exactly the following cycle. The flags and `wr_en`/`wr_idx`/`wr_data` are valid in that same cycle. `wr_en`, `wr_idx` and `wr_data` read 0 when nothing was written. A word issued in the next cycle already reads the new value.
- R12: When the destination equals either source, the operands are the values held before the write.
- R13: After reset every output is 0 and every register holds 0.
- R14: `fill_en` writes `fill_data` into register `fill_idx` at the clock edge. If an executed word targets the same register at the same edge, the executed result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| fill_en | input | 1 | Direct register write enable |
| fill_idx | input | 5 | Register written by the fill port |
| fill_data | input | 64 | Value written by the fill port |
| done | output | 1 | One-cycle pulse per accepted word |
| flag_unalloc | output | 1 | Word is an unallocated encoding |
| flag_unsupp | output | 1 | Word is recognised but not executed |
| wr_en | output | 1 | A register was written by the word |
| wr_idx | output | 5 | Register that was written |
| wr_data | output | 64 | Value that was written |

## Verification
Directed words run each operation on 0, all ones, the most negative value, 1 and the most positive value. This separates signed from unsigned ordering, which disagree whenever exactly one operand has its top bit set. Bit-test and equality are run on disjoint, overlapping and identical patterns, which tells the AND-nonzero test apart from the equality test. The full floating-point code space and every size of the size-gated opcodes are swept to confirm the unsupported/unallocated split. Overlapping destination/source words and back-to-back issue show the read-before-write order and the forwarding through the register file. Seeded random words over all 32 opcodes, run on a pool of boundary and random values, then compare class and write-back against bench functions.

// File: rtl/s3s_pkg.sv
// Package: shared field layout, word classes and operation codes for the
// scalar three-operand unit. Field positions are fixed by the encoding.
package s3s_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int OPC_W     = 5;

    localparam int DST_LSB   = 0;
    localparam int SRCA_LSB  = 5;
    localparam int OPC_LSB   = 11;
    localparam int SRCB_LSB  = 16;
    localparam int SIZE_LSB  = 22;
    localparam int UBIT_POS  = 29;

    typedef enum logic [1:0] {
        CLS_EXEC    = 2'd0,
        CLS_UNSUPP  = 2'd1,
        CLS_UNALLOC = 2'd2
    } word_class_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_SGT = 3'd2,
        OP_UGT = 3'd3,
        OP_SGE = 3'd4,
        OP_UGE = 3'd5,
        OP_EQ  = 3'd6,
        OP_TST = 3'd7
    } exec_op_e;

    typedef struct packed {
        logic [REG_IDX_W-1:0] dst;
        logic [REG_IDX_W-1:0] srca;
        logic [REG_IDX_W-1:0] srcb;
        logic [OPC_W-1:0]     opc;
        logic [1:0]           size;
        logic                 ubit;
    } word_fields_t;

    // Slice an instruction word into its named fields.
    function automatic word_fields_t split_word(input logic [WORD_W-1:0] w);
        word_fields_t f;
        f.dst  = w[DST_LSB  +: REG_IDX_W];
        f.srca = w[SRCA_LSB +: REG_IDX_W];
        f.srcb = w[SRCB_LSB +: REG_IDX_W];
        f.opc  = w[OPC_LSB  +: OPC_W];
        f.size = w[SIZE_LSB +: 2];
        f.ubit = w[UBIT_POS];
        return f;
    endfunction

endpackage

// File: rtl/s3s_decode.sv
// Module: s3s_decode
// Sorts a word into executable / unsupported / unallocated and picks the
// operation for executable words. Purely combinational.
// Assumes: fields already sliced by s3s_pkg::split_word.
module s3s_decode
    import s3s_pkg::*;
(
    input  word_fields_t fields,
    output word_class_e  cls,
    output exec_op_e     op
);

    logic [6:0] fp_code;
    logic       size_full;
    logic       size_half_or_single;

    assign fp_code             = {fields.ubit, fields.size[1], fields.opc};
    assign size_full           = (fields.size == 2'd3);
    assign size_half_or_single = (fields.size == 2'd1) || (fields.size == 2'd2);

    // Class and operation selection from opcode, size and unsigned bit.
    always_comb begin
        cls = CLS_UNALLOC;
        op  = OP_ADD;
        if (fields.opc >= 5'h18) begin
            case (fp_code)
                7'h1B, 7'h1C, 7'h1F, 7'h3F, 7'h5C,
                7'h5D, 7'h7A, 7'h7C, 7'h7D: cls = CLS_UNSUPP;
                default:                    cls = CLS_UNALLOC;
            endcase
        end else begin
            case (fields.opc)
                5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B: cls = CLS_UNSUPP;
                5'h06: begin
                    op  = fields.ubit ? OP_UGT : OP_SGT;
                    cls = size_full ? CLS_EXEC : CLS_UNALLOC;
                end
                5'h07: begin
                    op  = fields.ubit ? OP_UGE : OP_SGE;
                    cls = size_full ? CLS_EXEC : CLS_UNALLOC;
                end
                5'h10: begin
                    op  = fields.ubit ? OP_SUB : OP_ADD;
                    cls = size_full ? CLS_EXEC : CLS_UNALLOC;
                end
                5'h11: begin
                    op  = fields.ubit ? OP_EQ : OP_TST;
                    cls = size_full ? CLS_EXEC : CLS_UNALLOC;
                end
                5'h16: cls = size_half_or_single ? CLS_UNSUPP : CLS_UNALLOC;
                default: cls = CLS_UNALLOC;
            endcase
        end
    end

endmodule

// File: rtl/s3s_alu.sv
// Module: s3s_alu
// Computes wrapping add/subtract and compare masks on DATA_W-bit operands.
// Assumes: operands are stable for the cycle; no flags are produced.
module s3s_alu
    import s3s_pkg::*;
#(
    parameter int DATA_W = 64
)(
    input  exec_op_e          op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              is_cmp
);

    logic              test_hit;
    logic [DATA_W-1:0] hit_wide;

    // Evaluate the single-bit test for the compare operations.
    always_comb begin
        case (op)
            OP_SGT:  test_hit = $signed(opa) >  $signed(opb);
            OP_UGT:  test_hit = opa >  opb;
            OP_SGE:  test_hit = $signed(opa) >= $signed(opb);
            OP_UGE:  test_hit = opa >= opb;
            OP_EQ:   test_hit = (opa == opb);
            OP_TST:  test_hit = |(opa & opb);
            default: test_hit = 1'b0;
        endcase
    end

    assign hit_wide = {{(DATA_W-1){1'b0}}, test_hit};

    // Select the arithmetic result or the negated test bit as a mask.
    always_comb begin
        is_cmp = 1'b1;
        result = {DATA_W{1'b0}} - hit_wide;
        case (op)
            OP_ADD: begin
                is_cmp = 1'b0;
                result = opa + opb;
            end
            OP_SUB: begin
                is_cmp = 1'b0;
                result = opa - opb;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/s3s_regfile.sv
// Module: s3s_regfile
// NUM_REGS x DATA_W register file: two combinational read ports, an execute
// write port and a fill write port. The execute write wins on a collision.
// Assumes: NUM_REGS <= 2**IDX_W.
module s3s_regfile #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              ex_we,
    input  logic [IDX_W-1:0]  ex_idx,
    input  logic [DATA_W-1:0] ex_data,
    input  logic              fl_we,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [DATA_W-1:0] fl_data
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    // Storage update: clear on reset, fill first, execute result last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= {DATA_W{1'b0}};
            end
        end else begin
            if (fl_we) begin
                regs[fl_idx] <= fl_data;
            end
            if (ex_we) begin
                regs[ex_idx] <= ex_data;
            end
        end
    end

    assign rd_data_a = regs[rd_idx_a];
    assign rd_data_b = regs[rd_idx_b];

    // R14
    ex_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_we |=> (regs[$past(ex_idx)] == $past(ex_data)));

    // R14
    fill_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && !(ex_we && ex_idx == fl_idx)) |=> (regs[$past(fl_idx)] == $past(fl_data)));

endmodule

// File: rtl/simd_scalar3_unit.sv
// Module: simd_scalar3_unit (top)
// Accepts one instruction word per valid cycle, decodes it, executes the
// integer add/sub/compare subset against the internal register file and
// reports done, class flags and the write-back one cycle later.
// Assumes: NUM_REGS = 32 to match the 5-bit index fields.
module simd_scalar3_unit
    import s3s_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 fill_en,
    input  logic [REG_IDX_W-1:0] fill_idx,
    input  logic [DATA_W-1:0]    fill_data,
    output logic                 done,
    output logic                 flag_unalloc,
    output logic                 flag_unsupp,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic [DATA_W-1:0]    wr_data
);

    word_fields_t      fields;
    word_class_e       cls;
    exec_op_e          op;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_y;
    logic              alu_cmp;
    logic              exec_go;
    logic              last_cmp;

    assign fields  = split_word(in_word);
    assign exec_go = in_valid && (cls == CLS_EXEC);

    s3s_decode u_decode (
        .fields (fields),
        .cls    (cls),
        .op     (op)
    );

    s3s_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (REG_IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (fields.srca),
        .rd_idx_b  (fields.srcb),
        .rd_data_a (opa),
        .rd_data_b (opb),
        .ex_we     (exec_go),
        .ex_idx    (fields.dst),
        .ex_data   (alu_y),
        .fl_we     (fill_en),
        .fl_idx    (fill_idx),
        .fl_data   (fill_data)
    );

    s3s_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .result (alu_y),
        .is_cmp (alu_cmp)
    );

    // Register the per-word report that accompanies the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            flag_unalloc <= 1'b0;
            flag_unsupp  <= 1'b0;
            wr_en        <= 1'b0;
            wr_idx       <= '0;
            wr_data      <= '0;
            last_cmp     <= 1'b0;
        end else begin
            done         <= in_valid;
            flag_unalloc <= in_valid && (cls == CLS_UNALLOC);
            flag_unsupp  <= in_valid && (cls == CLS_UNSUPP);
            wr_en        <= exec_go;
            wr_idx       <= exec_go ? fields.dst : '0;
            wr_data      <= exec_go ? alu_y : '0;
            last_cmp     <= exec_go && alu_cmp;
        end
    end

    // R11
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R11
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_unalloc && flag_unsupp));

    // R10
    flags_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unalloc || flag_unsupp) |-> done);

    // R7
    write_only_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && !flag_unalloc && !flag_unsupp));

    // R6
    cmp_is_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_cmp |-> (wr_data == '0 || wr_data == '1));

endmodule

// File: tb/simd_scalar3_unit_test.sv
module simd_scalar3_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        fill_en = 1'b0;
    logic [4:0]  fill_idx = '0;
    logic [63:0] fill_data = '0;
    logic        done, flag_unalloc, flag_unsupp, wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] model [32];
    logic [63:0] pool [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_scalar3_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data),
        .done(done), .flag_unalloc(flag_unalloc), .flag_unsupp(flag_unsupp),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    function automatic logic [31:0] mk(input bit u, input logic [1:0] sz,
                                       input logic [4:0] opc, input logic [4:0] rm,
                                       input logic [4:0] rn, input logic [4:0] rd);
        logic [31:0] w;
        w = 32'h5E20_0400;
        w[29] = u; w[23:22] = sz; w[20:16] = rm; w[15:11] = opc;
        w[9:5] = rn; w[4:0] = rd;
        return w;
    endfunction

    // 0 = executes, 1 = unsupported, 2 = unallocated
    function automatic int exp_cls(input logic [31:0] w);
        logic [4:0] o; logic [1:0] s; bit u;
        o = w[15:11]; s = w[23:22]; u = w[29];
        if (o >= 5'h18) begin
            if (!u && !s[1] && (o == 5'h1B || o == 5'h1C || o == 5'h1F)) return 1;
            if (!u && s[1] && o == 5'h1F) return 1;
            if (u && !s[1] && (o == 5'h1C || o == 5'h1D)) return 1;
            if (u && s[1] && (o == 5'h1A || o == 5'h1C || o == 5'h1D)) return 1;
            return 2;
        end
        if (o inside {5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B}) return 1;
        if (o == 5'h16) return (s == 2'd1 || s == 2'd2) ? 1 : 2;
        if (o inside {5'h06, 5'h07, 5'h10, 5'h11}) return (s == 2'd3) ? 0 : 2;
        return 2;
    endfunction

    function automatic logic [63:0] exp_val(input logic [31:0] w,
                                            input logic [63:0] a, input logic [63:0] b);
        bit t;
        t = 0;
        case (w[15:11])
            5'h10: return w[29] ? a - b : a + b;
            5'h06: t = w[29] ? (a > b) : ($signed(a) > $signed(b));
            5'h07: t = w[29] ? (a >= b) : ($signed(a) >= $signed(b));
            5'h11: t = w[29] ? (a == b) : ((a & b) != 64'd0);
            default: t = 0;
        endcase
        return t ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check the report of a word sampled one edge earlier; update the model.
    task automatic check_report(input logic [31:0] w, input logic [63:0] a,
                                input logic [63:0] b, input string tag);
        int ec;
        logic [3:0] act_f, exp_f;
        logic [63:0] ev;
        ec = exp_cls(w);
        act_f = {done, flag_unalloc, flag_unsupp, wr_en};
        exp_f = {1'b1, ec == 2, ec == 1, ec == 0};
        chk(act_f == exp_f, {tag, " flags"}, 64'(act_f), 64'(exp_f));
        if (ec == 0) begin
            ev = exp_val(w, a, b);
            chk(wr_idx == w[4:0] && wr_data == ev, {tag, " data"}, wr_data, ev);
            model[w[4:0]] = ev;
        end
    endtask

    task automatic run(input logic [31:0] w, input string tag);
        logic [63:0] a, b;
        a = model[w[9:5]]; b = model[w[20:16]];
        @(negedge clk); in_valid = 1'b1; in_word = w;
        @(negedge clk); in_valid = 1'b0;
        check_report(w, a, b, tag);
    endtask

    task automatic fill(input logic [4:0] idx, input logic [63:0] v);
        @(negedge clk); fill_en = 1'b1; fill_idx = idx; fill_data = v;
        @(negedge clk); fill_en = 1'b0;
        model[idx] = v;
    endtask

    // Read a register back through a nondestructive ADD with zero register 0.
    task automatic readback(input logic [4:0] idx, input string tag);
        run(mk(0, 2'd3, 5'h10, 5'd0, idx, idx), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w1, w2;
        logic [63:0] a1, b1, a2, b2;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) model[i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk({done, flag_unalloc, flag_unsupp, wr_en} == 4'b0 && wr_idx == 5'd0 && wr_data == 64'd0,
            "R13 outputs", wr_data, 64'd0);
        readback(5'd13, "R13 reg cleared");

        fill(5'd1, 64'd0);
        fill(5'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        fill(5'd3, 64'h8000_0000_0000_0000);
        fill(5'd4, 64'd1);
        fill(5'd5, 64'h7FFF_FFFF_FFFF_FFFF);
        fill(5'd6, 64'h0F0F_0F0F_0F0F_0F0F);
        fill(5'd7, 64'hF0F0_F0F0_F0F0_F0F0);
        readback(5'd3, "R14 fill");

        // R1: field positions, distinct rd/rn/rm
        run(mk(0, 2'd3, 5'h10, 5'd6, 5'd4, 5'd20), "R1 fields");
        // R2: wrap add and sub
        run(mk(0, 2'd3, 5'h10, 5'd4, 5'd2, 5'd8), "R2 add wrap");
        run(mk(1, 2'd3, 5'h10, 5'd4, 5'd1, 5'd9), "R2 sub wrap");
        run(mk(1, 2'd3, 5'h10, 5'd4, 5'd3, 5'd10), "R2 sub minneg");
        // R3: signed vs unsigned greater-than
        run(mk(0, 2'd3, 5'h06, 5'd4, 5'd3, 5'd11), "R3 sgt neg");
        run(mk(1, 2'd3, 5'h06, 5'd4, 5'd3, 5'd11), "R3 ugt neg");
        run(mk(0, 2'd3, 5'h06, 5'd3, 5'd5, 5'd11), "R3 sgt max");
        run(mk(0, 2'd3, 5'h06, 5'd5, 5'd5, 5'd11), "R3 sgt equal");
        // R4: greater-or-equal
        run(mk(0, 2'd3, 5'h07, 5'd2, 5'd2, 5'd12), "R4 sge equal");
        run(mk(0, 2'd3, 5'h07, 5'd1, 5'd2, 5'd12), "R4 sge minus1");
        run(mk(1, 2'd3, 5'h07, 5'd1, 5'd2, 5'd12), "R4 uge ones");
        run(mk(1, 2'd3, 5'h07, 5'd2, 5'd1, 5'd12), "R4 uge zero");
        // R5/R6: equality and bit test masks
        run(mk(1, 2'd3, 5'h11, 5'd2, 5'd2, 5'd14), "R5 eq same R6");
        run(mk(1, 2'd3, 5'h11, 5'd5, 5'd2, 5'd14), "R5 eq diff R6");
        run(mk(0, 2'd3, 5'h11, 5'd7, 5'd6, 5'd14), "R5 tst disjoint");
        run(mk(0, 2'd3, 5'h11, 5'd3, 5'd2, 5'd14), "R5 tst overlap");
        run(mk(0, 2'd3, 5'h11, 5'd1, 5'd1, 5'd14), "R5 tst zero");

        // R7: size gating leaves the destination untouched
        for (int s = 0; s < 3; s++) begin
            run(mk(0, 2'(s), 5'h10, 5'd4, 5'd2, 5'd3), "R7 size");
            run(mk(1, 2'(s), 5'h06, 5'd4, 5'd2, 5'd3), "R7 size");
            run(mk(1, 2'(s), 5'h11, 5'd4, 5'd2, 5'd3), "R7 size");
        end
        readback(5'd3, "R7 dst kept");

        // R8: unsupported integer opcodes and 0x16 by size
        run(mk(0, 2'd3, 5'h01, 5'd4, 5'd2, 5'd5), "R8 op01");
        run(mk(1, 2'd3, 5'h05, 5'd4, 5'd2, 5'd5), "R8 op05");
        run(mk(0, 2'd0, 5'h08, 5'd4, 5'd2, 5'd5), "R8 op08");
        run(mk(1, 2'd2, 5'h09, 5'd4, 5'd2, 5'd5), "R8 op09");
        run(mk(0, 2'd1, 5'h0A, 5'd4, 5'd2, 5'd5), "R8 op0A");
        run(mk(1, 2'd3, 5'h0B, 5'd4, 5'd2, 5'd5), "R8 op0B");
        for (int s = 0; s < 4; s++) run(mk(0, 2'(s), 5'h16, 5'd4, 5'd2, 5'd5), "R8 op16");
        readback(5'd5, "R8 dst kept");

        // R9: whole floating-point space
        for (int c = 0; c < 64; c++)
            run(mk(c[5], {c[4], c[3]}, {2'b11, c[2:0]}, 5'd4, 5'd2, 5'd6), "R9 fp");
        readback(5'd6, "R9 dst kept");

        // R10: other opcodes are unallocated
        run(mk(0, 2'd3, 5'h00, 5'd4, 5'd2, 5'd7), "R10 op00");
        run(mk(1, 2'd3, 5'h12, 5'd4, 5'd2, 5'd7), "R10 op12");
        run(mk(0, 2'd3, 5'h17, 5'd4, 5'd2, 5'd7), "R10 op17");
        readback(5'd7, "R10 dst kept");

        // R12: destination overlaps a source
        fill(5'd9, 64'h0123_4567_89AB_CDEF);
        run(mk(0, 2'd3, 5'h10, 5'd9, 5'd9, 5'd9), "R12 rd=rn=rm");
        run(mk(1, 2'd3, 5'h10, 5'd9, 5'd4, 5'd9), "R12 rd=rm");

        // R11: back-to-back issue, second reads the first result
        w1 = mk(0, 2'd3, 5'h10, 5'd4, 5'd5, 5'd15);
        w2 = mk(1, 2'd3, 5'h06, 5'd5, 5'd15, 5'd16);
        a1 = model[5]; b1 = model[4];
        @(negedge clk); in_valid = 1'b1; in_word = w1;
        @(negedge clk); in_word = w2;
        check_report(w1, a1, b1, "R11 first");
        a2 = model[15]; b2 = model[5];
        @(negedge clk); in_valid = 1'b0;
        check_report(w2, a2, b2, "R11 forwarded");
        @(negedge clk);
        chk(done == 1'b0, "R11 single pulse", 64'(done), 64'd0);

        // R14: fill and execute at the same edge on one register
        @(negedge clk); in_valid = 1'b1; in_word = mk(0, 2'd3, 5'h10, 5'd4, 5'd4, 5'd17);
        fill_en = 1'b1; fill_idx = 5'd17; fill_data = 64'hDEAD_BEEF_0000_0001;
        a1 = model[4];
        @(negedge clk); in_valid = 1'b0; fill_en = 1'b0;
        check_report(mk(0, 2'd3, 5'h10, 5'd4, 5'd4, 5'd17), a1, a1, "R14 collide");
        readback(5'd17, "R14 exec wins");

        // Random words over a boundary-heavy value pool
        pool[0] = 64'd0; pool[1] = '1; pool[2] = 64'h8000_0000_0000_0000;
        pool[3] = 64'h7FFF_FFFF_FFFF_FFFF; pool[4] = 64'd1;
        for (int i = 0; i < 400; i++) begin
            logic [1:0] sz;
            logic [4:0] opc;
            if (i % 4 == 0) begin
                logic [63:0] v;
                v = ($urandom % 2 == 0) ? pool[$urandom % 5] : {$urandom, $urandom};
                fill(5'(1 + $urandom % 31), v);
            end
            opc = ($urandom % 2 == 0) ? 5'($urandom) :
                  ((($urandom % 4) == 0) ? 5'h06 : (($urandom % 3) == 0) ? 5'h07 :
                   (($urandom % 2) == 0) ? 5'h10 : 5'h11);
            sz = ($urandom % 4 == 0) ? 2'($urandom) : 2'd3;
            run(mk(1'($urandom), sz, opc, 5'($urandom), 5'($urandom),
                   5'(1 + $urandom % 31)), "R10 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule